// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve

This block maps a stream of 10-bit colour samples through a programmable tone curve. It accepts one sample per clock, qualified by a valid strobe, and returns the mapped sample a fixed two cycles later. The curve has eight knees. Their inputs are fixed powers of two, from 8 up to 1024. Their outputs are programmed. Between neighbouring knees the output follows a straight line. Because every segment is a power of two wide, the interpolation needs only a multiply and an arithmetic shift, never a divide.

Each knee output is 10 bits wide and comes in two pieces. The low byte arrives on a per-knee byte lane. The two top bits arrive packed four knees to a shared byte. The register bank that holds these bytes lives outside the block, and so does its bus decoding. One copy of the block is instantiated per colour channel.

Top module: `pwl_gamma`

## Requirements
- R1: While rstN is low, outValid is 0 and outSample is 0.
- R2: outValid equals the inValid value sampled two rising clock edges earlier. Samples are never dropped, merged or reordered.
- R3: Knee j (j = 1..8) takes its low 8 bits from kneeLo[8*j-1 : 8*(j-1)]. Knees 1 to 4 take their top two bits from kneeHi[7:0], and knees 5 to 8 take theirs from kneeHi[15:8]. Within each byte, bits [7:6] belong to the first knee of its group, [5:4] to the second, [3:2] to the third and [1:0] to the fourth.
- R4: An input of exactly 2^(j+2), for j = 1..7, returns knee j unchanged. An input of 1023 returns knee 8 unchanged.
- R5: An input x below 8 returns floor(knee1 * x / 8). The line runs from an implicit point (0, 0) up to knee 1, so an input of 0 always gives 0.
- R6: An input x in [2^k, 2^(k+1)), for k = 3..9 and x not 1023, returns lo + floor((hi - lo) * (x - 2^k) / 2^k). Here lo is knee k-2 and hi is knee k-1. The difference is signed and the floor rounds towards minus infinity, so falling curves are handled.
- R7: Every valid output lies in 0..1023 and between the two knee values that bound the input's segment, inclusive.
- R8: While outValid is 0, outSample keeps its previous value.
- R9: The knee values in effect for a sample are those present on kneeLo and kneeHi in the cycle the sample is accepted. A later change to the knees does not alter a sample that is already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample qualifier |
| inSample | input | 10 | Input component value |
| kneeLo | input | 64 | Low bytes of knees 1..8, knee 1 in the least significant byte |
| kneeHi | input | 16 | Packed top bits of the knees, two bits per knee |
| outValid | output | 1 | Output sample qualifier |
| outSample | output | 10 | Mapped component value |

## Verification
The internal state that can go wrong is small: the captured segment base, the signed slope, the offset, the shift amount and the valid pipeline. Each of these shows up at the ports on the second edge after the sample that exercised it.

- A wrong segment choice or a wrong shift gives a value that misses the knee exactly at a power-of-two input, or falls outside the two bounding knees.
- A sign error only shows on falling curves, where the floor rounding differs from truncation.
- A mis-packed top-bit field moves the output by a multiple of 256 at the matching knee.
- A valid pipeline that is one stage short or long shifts outValid by a cycle on the first sample after an idle gap.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;

  // Per-cycle enables from the control side to the datapath registers.
  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } pwl_strobe_t;

endpackage

// File: rtl/pwl_gamma_knees.sv
module pwl_gamma_knees #(
  parameter int DATA_W    = 10,
  parameter int NUM_KNEES = 8,
  parameter int LO_W      = 8
) (
  input  logic [NUM_KNEES*LO_W-1:0]                       kneeLo,
  input  logic [NUM_KNEES/(8/(DATA_W-LO_W))*8-1:0]        kneeHi,
  output logic [NUM_KNEES-1:0][DATA_W-1:0]                kneeVal
);
  localparam int HI_W     = DATA_W - LO_W;
  localparam int PER_BYTE = 8 / HI_W;

  // Each knee joins its own low byte with a slice of a shared high byte.
  // The first knee of a group sits in the top bits of that byte.
  for (genvar j = 0; j < NUM_KNEES; j++) begin : g_knee
    localparam int GRP = j / PER_BYTE;
    localparam int POS = j % PER_BYTE;
    assign kneeVal[j] = {kneeHi[GRP*8 + (PER_BYTE-1-POS)*HI_W +: HI_W],
                         kneeLo[j*LO_W +: LO_W]};
  end

endmodule

// File: rtl/pwl_gamma_ctrl.sv
module pwl_gamma_ctrl
  import pwl_gamma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pwl_strobe_t strobe,
  output logic        outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  // Registers only move for real samples, so idle cycles hold the output.
  always_comb begin
    strobe.loadStage1 = inValid;
    strobe.loadStage2 = stage1Valid;
  end

  assign outValid = stage2Valid;

endmodule

// File: rtl/pwl_gamma_dp.sv
module pwl_gamma_dp
  import pwl_gamma_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int NUM_KNEES  = 8,
  parameter int FIRST_LOG2 = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  pwl_strobe_t                      strobe,
  input  logic [DATA_W-1:0]                inSample,
  input  logic [NUM_KNEES-1:0][DATA_W-1:0] kneeVal,
  output logic [DATA_W-1:0]                outSample
);
  localparam int SEG_W   = $clog2(NUM_KNEES);
  localparam int SHIFT_W = $clog2(DATA_W + 1);
  localparam int OFF_W   = DATA_W - 1;
  localparam int DIFF_W  = DATA_W + 1;
  localparam int PROD_W  = DIFF_W + OFF_W + 1;
  localparam int SUM_W   = PROD_W + 1;
  localparam logic [DATA_W-1:0] MAX_OUT = '1;

  // ---------------- stage 1: segment selection ----------------
  logic [SEG_W-1:0]         segIdx;
  logic [SEG_W-1:0]         lowIdx;
  logic [DATA_W-1:0]        lowerK;
  logic [DATA_W-1:0]        upperK;
  logic [SHIFT_W-1:0]       shiftC;
  logic [DATA_W-1:0]        baseC;
  logic [DATA_W-1:0]        offFull;
  logic                     topHit;
  logic [DATA_W-1:0]        lowerC;
  logic signed [DIFF_W-1:0] diffC;

  // Highest set bit at or above FIRST_LOG2 picks the segment; 0 means below the first knee.
  always_comb begin
    segIdx = '0;
    for (int b = FIRST_LOG2; b < DATA_W; b++) begin
      if (inSample[b]) segIdx = SEG_W'(b - FIRST_LOG2 + 1);
    end
  end

  assign lowIdx = segIdx - 1'b1;
  assign lowerK = (segIdx == '0) ? '0 : kneeVal[lowIdx];
  assign upperK = kneeVal[segIdx];
  assign shiftC = (segIdx == '0) ? SHIFT_W'(FIRST_LOG2)
                                 : SHIFT_W'(segIdx) + SHIFT_W'(FIRST_LOG2 - 1);
  assign baseC  = (segIdx == '0) ? '0 : (DATA_W'(1) << shiftC);
  assign offFull = inSample - baseC;
  assign topHit = &inSample;

  // The last code lands on the top knee itself: zero slope from that knee.
  always_comb begin
    if (topHit) begin
      lowerC = kneeVal[NUM_KNEES-1];
      diffC  = '0;
    end else begin
      lowerC = lowerK;
      diffC  = $signed({1'b0, upperK}) - $signed({1'b0, lowerK});
    end
  end

  logic [DATA_W-1:0]        s1Lower;
  logic signed [DIFF_W-1:0] s1Diff;
  logic [OFF_W-1:0]         s1Off;
  logic [SHIFT_W-1:0]       s1Shift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Lower <= '0;
      s1Diff  <= '0;
      s1Off   <= '0;
      s1Shift <= '0;
    end else if (strobe.loadStage1) begin
      s1Lower <= lowerC;
      s1Diff  <= diffC;
      s1Off   <= offFull[OFF_W-1:0];
      s1Shift <= shiftC;
    end
  end

  // ---------------- stage 2: interpolate and clamp ----------------
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [SUM_W-1:0]  sum;
  logic [DATA_W-1:0]        clamped;

  assign prod   = s1Diff * $signed({1'b0, s1Off});
  assign scaled = prod >>> s1Shift;
  assign sum    = $signed({{(SUM_W-DATA_W){1'b0}}, s1Lower}) + SUM_W'(scaled);

  always_comb begin
    if (sum < 0)
      clamped = '0;
    else if (sum > $signed({{(SUM_W-DATA_W){1'b0}}, MAX_OUT}))
      clamped = MAX_OUT;
    else
      clamped = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outSample <= '0;
    else if (strobe.loadStage2)
      outSample <= clamped;
  end

endmodule

// File: rtl/pwl_gamma.sv
module pwl_gamma
  import pwl_gamma_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int NUM_KNEES  = 8,
  parameter int LO_W       = 8,
  parameter int FIRST_LOG2 = 3
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        inValid,
  input  logic [DATA_W-1:0]                           inSample,
  input  logic [NUM_KNEES*LO_W-1:0]                   kneeLo,
  input  logic [NUM_KNEES/(8/(DATA_W-LO_W))*8-1:0]    kneeHi,
  output logic                                        outValid,
  output logic [DATA_W-1:0]                           outSample
);
  pwl_strobe_t                      strobe;
  logic [NUM_KNEES-1:0][DATA_W-1:0] kneeVal;

  pwl_gamma_knees #(.DATA_W(DATA_W), .NUM_KNEES(NUM_KNEES), .LO_W(LO_W)) u_knees (
    .kneeLo (kneeLo),
    .kneeHi (kneeHi),
    .kneeVal(kneeVal)
  );

  pwl_gamma_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pwl_gamma_dp #(.DATA_W(DATA_W), .NUM_KNEES(NUM_KNEES), .FIRST_LOG2(FIRST_LOG2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .kneeVal  (kneeVal),
    .outSample(outSample)
  );

endmodule

// File: rtl/pwl_gamma_chk.sv
module pwl_gamma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [9:0]  inSample,
  input logic [63:0] kneeLo,
  input logic [15:0] kneeHi,
  input logic        outValid,
  input logic [9:0]  outSample
);
  function automatic logic [9:0] kneeAt(input logic [63:0] lo, input logic [15:0] hi, input int j);
    int g;
    int p;
    g = (j - 1) / 4;
    p = (j - 1) % 4;
    return {hi[g*8 + (3-p)*2 +: 2], lo[(j-1)*8 +: 8]};
  endfunction

  // Expected bounds and exact points, derived from the input-side ports.
  logic [9:0] bMin;
  logic [9:0] bMax;
  logic       exactHit;
  logic [9:0] exactVal;
  logic       zeroIn;

  always_comb begin
    logic [9:0] a;
    logic [9:0] b;
    int k;
    k = 0;
    for (int i = 3; i < 10; i++) if (inSample[i]) k = i;
    exactHit = 1'b0;
    exactVal = '0;
    if (k == 0) begin
      a = '0;
      b = kneeAt(kneeLo, kneeHi, 1);
    end else begin
      a = kneeAt(kneeLo, kneeHi, k - 2);
      b = kneeAt(kneeLo, kneeHi, k - 1);
      if (inSample == 10'(1 << k)) begin
        exactHit = 1'b1;
        exactVal = a;
      end
    end
    if (&inSample) begin
      exactHit = 1'b1;
      exactVal = kneeAt(kneeLo, kneeHi, 8);
      a = exactVal;
      b = exactVal;
    end
    bMin = (a < b) ? a : b;
    bMax = (a < b) ? b : a;
    zeroIn = (inSample == '0);
  end

  logic [1:0] vPipe;
  logic [9:0] minP1, minP2, maxP1, maxP2, hitVP1, hitVP2;
  logic       hitP1, hitP2, zeroP1, zeroP2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
      minP1 <= '0; minP2 <= '0; maxP1 <= '0; maxP2 <= '0;
      hitVP1 <= '0; hitVP2 <= '0;
      hitP1 <= 1'b0; hitP2 <= 1'b0; zeroP1 <= 1'b0; zeroP2 <= 1'b0;
    end else begin
      vPipe  <= {vPipe[0], inValid};
      minP1  <= bMin;     minP2  <= minP1;
      maxP1  <= bMax;     maxP2  <= maxP1;
      hitP1  <= exactHit; hitP2  <= hitP1;
      hitVP1 <= exactVal; hitVP2 <= hitVP1;
      zeroP1 <= zeroIn;   zeroP2 <= zeroP1;
    end
  end

  // R2: a sample emerges exactly two edges after acceptance
  a_r2_valid_on: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

  // R8: idle cycles do not disturb the output value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample));

  // R7: output stays between the knees bounding the input segment
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (vPipe[1] && outValid) |-> (outSample >= minP2 && outSample <= maxP2));

  // R4: knee inputs return the programmed knee
  a_r4_knee_hit: assert property (@(posedge clk) disable iff (!rstN)
    (vPipe[1] && hitP2) |-> (outSample == hitVP2));

  // R5: zero input maps to zero
  a_r5_zero_in: assert property (@(posedge clk) disable iff (!rstN)
    (vPipe[1] && zeroP2) |-> (outSample == '0));

  // R1: reset state visible at the outputs
  always_comb begin
    if (!rstN) a_r1_reset_out: assert (outValid == 1'b0 && outSample == '0);
  end

endmodule

bind pwl_gamma pwl_gamma_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inSample (inSample),
  .kneeLo   (kneeLo),
  .kneeHi   (kneeHi),
  .outValid (outValid),
  .outSample(outSample)
);

// File: tb/pwl_gamma_bench.sv
`timescale 1ns/1ps
module pwl_gamma_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  inSample = '0;
  logic [63:0] kneeLo;
  logic [15:0] kneeHi;
  logic        outValid;
  logic [9:0]  outSample;

  int applied = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwl_gamma u_pwl_gamma (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .kneeLo(kneeLo), .kneeHi(kneeHi), .outValid(outValid), .outSample(outSample)
  );

  // Pending knee programme, pushed to the ports by applyKnees.
  logic [63:0] pendLo;
  logic [15:0] pendHi;

  function automatic int kneeOf(int j);
    int lo, hi, g, p;
    lo = int'(kneeLo[(j-1)*8 +: 8]);
    g = (j - 1) / 4;
    p = (j - 1) % 4;
    hi = int'(kneeHi[g*8 + (3-p)*2 +: 2]);
    return hi * 256 + lo;
  endfunction

  function automatic void setKnee(int j, int v);
    int g, p;
    g = (j - 1) / 4;
    p = (j - 1) % 4;
    pendLo[(j-1)*8 +: 8] = 8'(v % 256);
    pendHi[g*8 + (3-p)*2 +: 2] = 2'(v / 256);
  endfunction

  function automatic int model(int x);
    int lo, up, base, sh, k, prod, den, q, r;
    if (x == 1023) return kneeOf(8);
    if (x < 8) begin
      lo = 0; up = kneeOf(1); base = 0; sh = 3;
    end else begin
      k = 3;
      while ((1 << (k + 1)) <= x) k++;
      lo = kneeOf(k - 2); up = kneeOf(k - 1); base = 1 << k; sh = k;
    end
    prod = (up - lo) * (x - base);
    den = 1 << sh;
    if (prod >= 0) q = prod / den;
    else q = -((-prod + den - 1) / den);
    r = lo + q;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  // Two-deep record of what was driven, to compare when it emerges.
  bit    histV [2];
  int    histE [2];
  string histT [2];
  int    lastOut = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic applyKnees();
    @(posedge clk);
    #1;
    kneeLo = pendLo;
    kneeHi = pendHi;
  endtask

  task automatic step(bit v, int x, string tag);
    @(negedge clk);
    if (histV[1]) begin
      check(outValid == 1'b1, "R2", int'(outValid), 1);
      check(int'(outSample) == histE[1], histT[1], int'(outSample), histE[1]);
      lastOut = histE[1];
    end else begin
      check(outValid == 1'b0, "R2", int'(outValid), 0);
      check(int'(outSample) == lastOut, "R8", int'(outSample), lastOut);
    end
    histV[1] = histV[0]; histE[1] = histE[0]; histT[1] = histT[0];
    histV[0] = v;
    histE[0] = v ? model(x) : 0;
    histT[0] = tag;
    inValid = v;
    inSample = 10'(x);
  endtask

  task automatic flush();
    step(0, 0, "");
    step(0, 0, "");
    step(0, 0, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'd2718);
    // Identity programme: 8,16,32,64,128,256,512,1023.
    pendLo = 64'hFF00_0080_4020_1008;
    pendHi = 16'h1B00;
    kneeLo = pendLo;
    kneeHi = pendHi;
    histV[0] = 0; histV[1] = 0; histE[0] = 0; histE[1] = 0;

    // R1: reset outputs, with activity on the input
    inValid = 1'b1;
    inSample = 10'd700;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outSample == '0, "R1", int'(outSample), 0);
    inValid = 1'b0;
    rstN = 1'b1;

    // R4 identity knees and top code
    for (int j = 1; j <= 7; j++) step(1, 1 << (j + 2), "R4");
    step(1, 1023, "R4");
    // R5 below the first knee
    for (int x = 0; x < 8; x++) step(1, x, "R5");
    flush();

    // R3: distinct top bits per knee, checked at each knee input
    setKnee(1, 3*256 + 17); setKnee(2, 2*256 + 40); setKnee(3, 1*256 + 99);
    setKnee(4, 0*256 + 200); setKnee(5, 1*256 + 5); setKnee(6, 3*256 + 250);
    setKnee(7, 2*256 + 128); setKnee(8, 0*256 + 77);
    applyKnees();
    for (int j = 1; j <= 7; j++) step(1, 1 << (j + 2), "R3");
    step(1, 1023, "R3");
    step(1, 4, "R5");
    step(1, 0, "R5");
    flush();

    // R6: falling curve, floor rounding on negative slopes
    for (int j = 1; j <= 8; j++) setKnee(j, 1020 - 120 * j);
    applyKnees();
    for (int i = 0; i < 60; i++) step(1, int'($urandom_range(0, 1023)), "R6");
    step(1, 511, "R6");
    step(1, 1022, "R6");
    step(1, 15, "R6");
    flush();

    // R7: extreme alternating knees
    for (int j = 1; j <= 8; j++) setKnee(j, (j % 2) ? 1023 : 0);
    applyKnees();
    for (int i = 0; i < 60; i++) step(1, int'($urandom_range(0, 1023)), "R7");
    step(1, 1022, "R7");
    step(1, 1, "R7");

    // R9: one sample in flight when the knees change, next sample sees new ones
    step(1, 300, "R9");
    for (int j = 1; j <= 8; j++) setKnee(j, 64 * j + 3);
    applyKnees();
    step(1, 300, "R9");
    step(1, 700, "R9");
    flush();

    // R6/R8: random knees, random input, random idle gaps
    for (int r = 0; r < 20; r++) begin
      for (int j = 1; j <= 8; j++) setKnee(j, int'($urandom_range(0, 1023)));
      applyKnees();
      for (int i = 0; i < 80; i++) begin
        if ($urandom_range(0, 3) == 0) step(0, int'($urandom_range(0, 1023)), "R8");
        else step(1, int'($urandom_range(0, 1023)), "R6");
      end
      flush();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule